// File: doc/BRIEF.md
# Per-Port Adaptive Flow Control Gate

This block sits beside one switch port. It decides whether the port may push back on its link partner while its buffers are congested. In full duplex that push-back is a pause request. In half duplex it is a forced-collision (jam) request. Three enable straps are captured once when reset is released and are held from then on. The straps enable pause, enable back pressure, and enable the high-priority auto-off feature.

In half duplex the gate counts the forced collisions it has caused. After a fixed number of them, 48 by default, it opens a pass window that lets exactly one frame through, and then it goes back to jamming. This keeps an attached repeater from isolating the segment for excessive collisions.

When auto-off is enabled, each received high-priority frame suspends both mechanisms. A free-running hold tick is derived from a millisecond tick input. The suspension ends between one and two hold periods after the last high-priority frame, because every new frame restarts the window.

Top module: `port_fc_gate`

## Requirements
- R1: The three straps are captured on the first clock edge after `rst_n` goes high. Later changes on the strap inputs have no effect on the outputs.
- R2: `pause_req` is high exactly when the port is in full duplex (`full_duplex`=1), the pause strap was captured high, `congest_req` is high and the port is not suspended.
- R3: `jam_req` is high exactly when the port is in half duplex (`full_duplex`=0), the back-pressure strap was captured high, `congest_req` is high, the port is not suspended and no pass window is open.
- R4: While back pressure is active, the COLL_LIMIT-th (48th) `coll_done` pulse opens the pass window from the next cycle: `pass_window` goes high and `jam_req` goes low. Fewer pulses leave the window closed.
- R5: A `frame_done` pulse during an open window closes it from the next cycle and jamming resumes. A further full COLL_LIMIT collisions are then needed to reopen it.
- R6: Dropping `congest_req` or switching to full duplex clears the collision count and any open window.
- R7: With the auto-off strap captured high, a `hp_rx_pulse` forces `pause_req` and `jam_req` low from the next cycle.
- R8: A hold tick occurs on every HOLD_MS-th `ms_tick` pulse after reset. The suspension survives the first hold tick after the last high-priority frame and ends at the second one. A new frame restarts the window.
- R9: With the auto-off strap captured low, `hp_rx_pulse` has no effect.
- R10: While `rst_n` is low, and until the straps are captured, all outputs are low.
- R11: A suspension clears the collision count, so counting restarts from zero when back pressure resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_pause_en | input | 1 | Enable strap for full-duplex pause, captured after reset |
| strap_bp_en | input | 1 | Enable strap for half-duplex back pressure |
| strap_autooff_en | input | 1 | Enable strap for high-priority auto-off |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| congest_req | input | 1 | Buffer congestion request |
| hp_rx_pulse | input | 1 | One-cycle pulse per received high-priority frame |
| coll_done | input | 1 | One-cycle pulse per completed forced collision |
| frame_done | input | 1 | One-cycle pulse when a frame has been forwarded |
| ms_tick | input | 1 | One-cycle millisecond tick |
| pause_req | output | 1 | Request to send pause frames |
| jam_req | output | 1 | Request to force collisions |
| pass_window | output | 1 | One-frame pass window is open |

## Verification
The bench targets the collision boundary. It drives 47 pulses and then the 48th. A design off by one would open the window one collision early or late. The bench checks that a closed window needs a fresh 48 collisions, and that a congestion drop or a suspension discards a partial count. A design that kept a stale count would open the window too soon. It also places the hold ticks exactly and retriggers the suspension just before expiry. A single-stage flag would release flow control after one tick, and a timer that was not restarted would release it too early. Changing the straps after capture shows whether they are still being sampled live.

// File: rtl/fc_gate_pkg.sv
package fc_gate_pkg;

  typedef struct packed {
    logic pause_en;
    logic bp_en;
    logic autooff_en;
  } fc_straps_t;

  // Two-stage suspension flag: a new frame sets both stages,
  // and each hold tick shifts them down by one.
  function automatic logic [1:0] hold_next(input logic [1:0] st,
                                           input logic       hp,
                                           input logic       tick);
    if (hp)   return 2'b11;
    if (tick) return {1'b0, st[1]};
    return st;
  endfunction

  // True when a count value is the last one before the limit.
  function automatic logic is_last(input int unsigned cnt,
                                   input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/fc_strap_latch.sv
module fc_strap_latch
  import fc_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fc_straps_t straps_in,
  output fc_straps_t straps_q,
  output logic       armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      straps_q <= '0;
      armed    <= 1'b0;
    end else if (!armed) begin
      straps_q <= straps_in;
      armed    <= 1'b1;
    end
  end

endmodule

// File: rtl/fc_hold_timer.sv
module fc_hold_timer
  import fc_gate_pkg::*;
#(
  parameter int HOLD_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic hp_rx,
  input  logic enable,
  output logic hold_tick,
  output logic suspended
);

  localparam int HC_W = (HOLD_MS > 1) ? $clog2(HOLD_MS) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HOLD_MS - 1);

  logic [HC_W-1:0] ms_cnt;
  logic [1:0]      stage;

  assign hold_tick = ms_tick && (ms_cnt == HC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt <= '0;
    end else if (ms_tick) begin
      ms_cnt <= hold_tick ? '0 : ms_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= 2'b00;
    end else begin
      stage <= hold_next(stage, hp_rx && enable, hold_tick);
    end
  end

  assign suspended = |stage;

endmodule

// File: rtl/fc_bp_pacer.sv
module fc_bp_pacer
  import fc_gate_pkg::*;
#(
  parameter int COLL_LIMIT = 48,
  parameter int CNT_W      = $clog2(COLL_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bp_active,
  input  logic             coll_done,
  input  logic             frame_done,
  output logic             win_q,
  output logic [CNT_W-1:0] coll_count,
  output logic             win_open_evt
);

  assign win_open_evt = bp_active && !win_q && coll_done &&
                        is_last(int'(coll_count), COLL_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_count <= '0;
      win_q      <= 1'b0;
    end else if (!bp_active) begin
      coll_count <= '0;
      win_q      <= 1'b0;
    end else if (win_q) begin
      if (frame_done) win_q <= 1'b0;
    end else if (win_open_evt) begin
      coll_count <= '0;
      win_q      <= 1'b1;
    end else if (coll_done) begin
      coll_count <= coll_count + 1'b1;
    end
  end

endmodule

// File: rtl/port_fc_gate.sv
module port_fc_gate
  import fc_gate_pkg::*;
#(
  parameter int COLL_LIMIT = 48,
  parameter int HOLD_MS    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_pause_en,
  input  logic strap_bp_en,
  input  logic strap_autooff_en,
  input  logic full_duplex,
  input  logic congest_req,
  input  logic hp_rx_pulse,
  input  logic coll_done,
  input  logic frame_done,
  input  logic ms_tick,
  output logic pause_req,
  output logic jam_req,
  output logic pass_window
);

  localparam int CNT_W = $clog2(COLL_LIMIT);

  fc_straps_t       straps_in;
  fc_straps_t       straps_q;
  logic             armed;
  logic             hold_tick;
  logic             suspended;
  logic             bp_active;
  logic             win_q;
  logic             win_open_evt;
  logic [CNT_W-1:0] coll_count;

  assign straps_in = '{pause_en: strap_pause_en,
                       bp_en: strap_bp_en,
                       autooff_en: strap_autooff_en};

  fc_strap_latch u_straps (
    .clk       (clk),
    .rst_n     (rst_n),
    .straps_in (straps_in),
    .straps_q  (straps_q),
    .armed     (armed)
  );

  fc_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .hp_rx     (hp_rx_pulse),
    .enable    (armed && straps_q.autooff_en),
    .hold_tick (hold_tick),
    .suspended (suspended)
  );

  assign bp_active = armed && straps_q.bp_en && !full_duplex &&
                     congest_req && !suspended;

  fc_bp_pacer #(.COLL_LIMIT(COLL_LIMIT), .CNT_W(CNT_W)) u_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .bp_active    (bp_active),
    .coll_done    (coll_done),
    .frame_done   (frame_done),
    .win_q        (win_q),
    .coll_count   (coll_count),
    .win_open_evt (win_open_evt)
  );

  assign pause_req   = armed && straps_q.pause_en && full_duplex &&
                       congest_req && !suspended;
  assign jam_req     = bp_active && !win_q;
  assign pass_window = bp_active && win_q;

endmodule

// File: rtl/port_fc_gate_chk.sv
module port_fc_gate_chk
  import fc_gate_pkg::*;
#(
  parameter int COLL_LIMIT = 48,
  parameter int CNT_W      = $clog2(COLL_LIMIT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input fc_straps_t       straps_q,
  input logic             hp_rx_pulse,
  input logic             coll_done,
  input logic             frame_done,
  input logic             congest_req,
  input logic             pause_req,
  input logic             jam_req,
  input logic             pass_window,
  input logic [CNT_W-1:0] coll_count
);

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed) |-> $stable(straps_q)); // R1

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_req && jam_req)); // R2

  AST_WIN_AFTER_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_window) |-> $past(coll_done)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(coll_count) < COLL_LIMIT); // R4

  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_window && frame_done |=> !pass_window); // R5

  AST_CONGEST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !congest_req |=> !pass_window); // R6

  AST_HP_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    hp_rx_pulse && armed && straps_q.autooff_en |=> !pause_req && !jam_req); // R7

  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pause_req && !jam_req && !pass_window); // R10

endmodule

bind port_fc_gate port_fc_gate_chk #(.COLL_LIMIT(COLL_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .armed       (armed),
  .straps_q    (straps_q),
  .hp_rx_pulse (hp_rx_pulse),
  .coll_done   (coll_done),
  .frame_done  (frame_done),
  .congest_req (congest_req),
  .pause_req   (pause_req),
  .jam_req     (jam_req),
  .pass_window (pass_window),
  .coll_count  (coll_count)
);

// File: tb/port_fc_gate_bench.sv
module port_fc_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 48;
  localparam int HOLD       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_pause = 1'b1, s_bp = 1'b1, s_auto = 1'b1;
  logic fd = 1'b1, cg = 1'b1, hp = 1'b0, coll = 1'b0, fdone = 1'b0, ms = 1'b0;
  logic pause_req, jam_req, pass_window;

  int nchk = 0;
  int nfail = 0;
  int msn = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_fc_gate #(.COLL_LIMIT(LIMIT), .HOLD_MS(HOLD)) u_port_fc_gate (
    .clk(clk), .rst_n(rst_n),
    .strap_pause_en(s_pause), .strap_bp_en(s_bp), .strap_autooff_en(s_auto),
    .full_duplex(fd), .congest_req(cg), .hp_rx_pulse(hp),
    .coll_done(coll), .frame_done(fdone), .ms_tick(ms),
    .pause_req(pause_req), .jam_req(jam_req), .pass_window(pass_window)
  );

  // Each entry: {full_duplex, congest, expected pause, expected jam}
  localparam logic [3:0] VEC [4] = '{4'b1110, 4'b0101, 4'b1000, 4'b0000};

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input logic p, input logic b, input logic a);
    @(negedge clk);
    rst_n = 1'b0; s_pause = p; s_bp = b; s_auto = a; msn = 0;
    hp = 0; coll = 0; fdone = 0; ms = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic pulse_coll(input int n);
    for (int i = 0; i < n; i++) begin
      coll = 1'b1; cyc(); coll = 1'b0;
    end
  endtask

  task automatic pulse_hp();
    hp = 1'b1; cyc(); hp = 1'b0;
  endtask

  // Issue ms ticks until one of them is a hold tick (every HOLD-th pulse).
  task automatic wait_hold();
    bit seen;
    seen = 1'b0;
    while (!seen) begin
      ms = 1'b1; cyc(); ms = 1'b0;
      msn++;
      seen = (msn % HOLD) == 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R10: outputs quiet while held in reset, even with congestion
    cyc();
    chk("R10 pause in reset", pause_req, 1'b0);
    chk("R10 jam in reset", jam_req, 1'b0);
    chk("R10 window in reset", pass_window, 1'b0);
    do_reset(1, 1, 1);

    // R2/R3 table walk
    for (int i = 0; i < 4; i++) begin
      fd = VEC[i][3]; cg = VEC[i][2];
      #1;
      chk("R2 table pause", pause_req, VEC[i][1]);
      chk("R3 table jam", jam_req, VEC[i][0]);
    end

    // R1: strap changes after capture are ignored
    fd = 1; cg = 1; s_pause = 0; cyc(); cyc();
    chk("R1 pause strap ignored", pause_req, 1'b1);
    do_reset(0, 0, 0);
    fd = 1; cg = 1; #1;
    chk("R2 pause strap low", pause_req, 1'b0);
    s_pause = 1; cyc();
    chk("R1 late strap high ignored", pause_req, 1'b0);
    fd = 0; #1;
    chk("R3 bp strap low", jam_req, 1'b0);

    // R4/R5: collision window
    do_reset(1, 1, 1);
    fd = 0; cg = 1; cyc();
    pulse_coll(LIMIT - 1);
    chk("R4 window closed at 47", pass_window, 1'b0);
    chk("R4 jam at 47", jam_req, 1'b1);
    pulse_coll(1);
    chk("R4 window open at 48", pass_window, 1'b1);
    chk("R4 jam off in window", jam_req, 1'b0);
    fdone = 1; cyc(); fdone = 0;
    chk("R5 window closed by frame", pass_window, 1'b0);
    chk("R5 jam resumes", jam_req, 1'b1);
    pulse_coll(LIMIT - 1);
    chk("R5 fresh count needed", pass_window, 1'b0);
    pulse_coll(1);
    chk("R5 reopen after 48", pass_window, 1'b1);

    // R6: congestion drop clears window and partial count
    cg = 0; cyc(); cg = 1; #1;
    chk("R6 window cleared", pass_window, 1'b0);
    pulse_coll(30);
    fd = 1; cyc(); fd = 0; cyc();
    pulse_coll(18);
    chk("R6 count cleared by duplex", pass_window, 1'b0);
    pulse_coll(LIMIT - 18);
    chk("R6 full count after clear", pass_window, 1'b1);
    fdone = 1; cyc(); fdone = 0;

    // R11: suspension discards partial count
    pulse_coll(40);
    pulse_hp();
    chk("R7 jam suspended", jam_req, 1'b0);
    wait_hold(); wait_hold();
    chk("R8 jam back after two ticks", jam_req, 1'b1);
    pulse_coll(8);
    chk("R11 count cleared by suspend", pass_window, 1'b0);
    pulse_coll(LIMIT - 8);
    chk("R11 window after full count", pass_window, 1'b1);

    // R7/R8: suspension window in full duplex
    fd = 1; cg = 1; cyc();
    chk("R2 pause before hp", pause_req, 1'b1);
    pulse_hp();
    chk("R7 pause suspended", pause_req, 1'b0);
    wait_hold();
    chk("R8 still suspended after first tick", pause_req, 1'b0);
    wait_hold();
    chk("R8 released after second tick", pause_req, 1'b1);
    pulse_hp();
    wait_hold();
    pulse_hp();
    wait_hold();
    chk("R8 retrigger holds", pause_req, 1'b0);
    wait_hold();
    chk("R8 retrigger release", pause_req, 1'b1);

    // R9: auto-off disabled
    do_reset(1, 1, 0);
    fd = 1; cg = 1; cyc();
    pulse_hp();
    chk("R9 hp ignored pause", pause_req, 1'b1);
    fd = 0; cyc();
    pulse_hp();
    chk("R9 hp ignored jam", jam_req, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule